// File: doc/BRIEF.md
# Adjacent-Repeat Word Line Codec

This block shrinks a 64-byte cache line, held as sixteen 32-bit words, by leaving out every word that equals the word just below it. The compress path turns a line into three results. The first is a 16-bit keep mask with one bit per word. The second is a packed word array that holds only the kept words. The third is the number of kept words. The decompress path takes a keep mask and a packed array and rebuilds the full line.

A third port is purely combinational. It returns any single original word straight from the keep mask and the packed array. It counts the mask bits up to and including the requested index, so it never searches and never expands the whole line.

Both the compress and decompress paths are registered. Each uses a valid/ready handshake and holds one result. A new request is accepted only after the previous result has left. Word 0 sits in bits [31:0] of every line and packed bus, and word i sits in bits [32i+31:32i].

Top module: `smc_line_codec`

## Requirements
- R1: For i from 1 to 15, keep-mask bit i is 1 exactly when word i of the line differs from word i-1.
- R2: Keep-mask bit 0 is always 1.
- R3: Kept words fill the packed array in ascending word order, starting at slot 0 (bits [31:0]). Every slot at or above the kept count reads zero.
- R4: The kept count equals the number of 1 bits in the keep mask. It lies between 1 (all words equal) and 16 (no adjacent pair equal).
- R5: On decompress, output word i equals packed slot (number of 1 bits in mask bits 0..i) minus 1. A word whose mask bit is 0 therefore repeats the word below it. Mask bit 0 is treated as 1 whatever its input value.
- R6: The lookup port returns original word lk_index combinationally, for any index, from a keep mask and packed array produced by compression.
- R7: A request accepted on a clock edge makes the matching output valid straight after that edge, so each path adds one cycle of latency.
- R8: While a path holds an output that has not been taken, its input ready is low and its output data stays unchanged. After reset, both outputs are invalid and both inputs are ready.
- R9: Decompressing the mask and packed array from a compression returns the original line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in_valid | input | 1 | Line offered for compression |
| cmp_in_ready | output | 1 | Compress path can accept |
| cmp_in_line | input | 512 | Line to compress, word 0 in the low bits |
| cmp_out_valid | output | 1 | Compression result available |
| cmp_out_ready | input | 1 | Consumer takes compression result |
| cmp_out_tag | output | 16 | Keep mask |
| cmp_out_words | output | 512 | Packed kept words, slot 0 in the low bits |
| cmp_out_count | output | 5 | Number of kept words |
| dec_in_valid | input | 1 | Compressed line offered for expansion |
| dec_in_ready | output | 1 | Decompress path can accept |
| dec_in_tag | input | 16 | Keep mask to expand |
| dec_in_words | input | 512 | Packed words to expand |
| dec_out_valid | output | 1 | Rebuilt line available |
| dec_out_ready | input | 1 | Consumer takes rebuilt line |
| dec_out_line | output | 512 | Rebuilt line |
| lk_tag | input | 16 | Keep mask for lookup |
| lk_words | input | 512 | Packed words for lookup |
| lk_index | input | 4 | Original word index requested |
| lk_word | output | 32 | Requested original word |

## Verification
The compress path is tried with several line patterns, each of which separates one kind of mistake. A line of identical words gives the minimum count of 1. Strictly distinct words and an alternating two-value line both give the full count of 16; the alternating line catches a design that compares against anything other than the immediate neighbour. A line with a long interior run and a repeated top group checks packing order. A line where only the top word differs checks the high mask bit. Lines drawn from a three-value alphabet mix runs at random positions. Every result is expanded again and probed through the lookup port at low, interior and top indices. Decompression is also run with mask bit 0 cleared, and the compress output is held under back-pressure.

// File: rtl/smc_pkg.sv
package smc_pkg;
    parameter int unsigned WORDS  = 16;
    parameter int unsigned WORD_W = 32;

    localparam int unsigned LINE_W = WORDS * WORD_W;
    localparam int unsigned CNT_W  = $clog2(WORDS + 1);
    localparam int unsigned IDX_W  = $clog2(WORDS);

    typedef logic [WORD_W-1:0]       word_t;
    typedef logic [WORDS-1:0]        tag_t;
    typedef word_t [WORDS-1:0]       words_t;
    typedef logic [CNT_W-1:0]        cnt_t;
    typedef logic [IDX_W-1:0]        idx_t;

    typedef struct packed {
        tag_t   tag;
        cnt_t   count;
        words_t kept;
    } cmp_res_t;

    // Ones in mask bits 0..idx; bit 0 always counts as set.
    function automatic cnt_t ones_through(tag_t t, idx_t idx);
        cnt_t n;
        n = '0;
        for (int j = 0; j < int'(WORDS); j++) begin
            if (j <= int'(idx) && (j == 0 || t[j])) begin
                n = n + cnt_t'(1);
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/smc_word_locator.sv
module smc_word_locator
    import smc_pkg::*;
(
    input  tag_t   tag_i,
    input  words_t kept_i,
    input  idx_t   idx_i,
    output word_t  word_o
);
    idx_t slot;

    assign slot   = idx_t'(ones_through(tag_i, idx_i) - cnt_t'(1));
    assign word_o = kept_i[slot];
endmodule

// File: rtl/smc_packer.sv
module smc_packer
    import smc_pkg::*;
(
    input  words_t line_i,
    output tag_t   tag_o,
    output words_t kept_o,
    output cnt_t   count_o
);
    idx_t slot [WORDS];

    always_comb begin
        tag_o[0] = 1'b1;
        for (int i = 1; i < int'(WORDS); i++) begin
            tag_o[i] = (line_i[i] != line_i[i-1]);
        end
    end

    for (genvar g = 0; g < int'(WORDS); g++) begin : g_slot
        assign slot[g] = idx_t'(ones_through(tag_o, idx_t'(g)) - cnt_t'(1));
    end

    always_comb begin
        kept_o = '0;
        for (int i = 0; i < int'(WORDS); i++) begin
            if (tag_o[i]) begin
                kept_o[slot[i]] = line_i[i];
            end
        end
    end

    assign count_o = ones_through(tag_o, idx_t'(WORDS - 1));
endmodule

// File: rtl/smc_unpacker.sv
module smc_unpacker
    import smc_pkg::*;
(
    input  tag_t   tag_i,
    input  words_t kept_i,
    output words_t line_o
);
    for (genvar g = 0; g < int'(WORDS); g++) begin : g_word
        smc_word_locator u_loc (
            .tag_i  (tag_i),
            .kept_i (kept_i),
            .idx_i  (idx_t'(g)),
            .word_o (line_o[g])
        );
    end
endmodule

// File: rtl/smc_hold_reg.sv
module smc_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/smc_line_codec.sv
module smc_line_codec
    import smc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_in_valid,
    output logic              cmp_in_ready,
    input  logic [LINE_W-1:0] cmp_in_line,
    output logic              cmp_out_valid,
    input  logic              cmp_out_ready,
    output logic [WORDS-1:0]  cmp_out_tag,
    output logic [LINE_W-1:0] cmp_out_words,
    output logic [CNT_W-1:0]  cmp_out_count,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [WORDS-1:0]  dec_in_tag,
    input  logic [LINE_W-1:0] dec_in_words,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [LINE_W-1:0] dec_out_line,
    input  logic [WORDS-1:0]  lk_tag,
    input  logic [LINE_W-1:0] lk_words,
    input  logic [IDX_W-1:0]  lk_index,
    output logic [WORD_W-1:0] lk_word
);
    localparam int unsigned CMP_W = $bits(cmp_res_t);

    cmp_res_t cmp_next;
    cmp_res_t cmp_held;
    words_t   dec_next;
    words_t   dec_held;

    smc_packer u_packer (
        .line_i  (words_t'(cmp_in_line)),
        .tag_o   (cmp_next.tag),
        .kept_o  (cmp_next.kept),
        .count_o (cmp_next.count)
    );

    smc_hold_reg #(.W(CMP_W)) u_cmp_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (cmp_in_valid),
        .in_ready  (cmp_in_ready),
        .in_data   (cmp_next),
        .out_valid (cmp_out_valid),
        .out_ready (cmp_out_ready),
        .out_data  (cmp_held)
    );

    assign cmp_out_tag   = cmp_held.tag;
    assign cmp_out_words = cmp_held.kept;
    assign cmp_out_count = cmp_held.count;

    smc_unpacker u_unpacker (
        .tag_i  (dec_in_tag),
        .kept_i (words_t'(dec_in_words)),
        .line_o (dec_next)
    );

    smc_hold_reg #(.W(LINE_W)) u_dec_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_data   (dec_next),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_data  (dec_held)
    );

    assign dec_out_line = dec_held;

    smc_word_locator u_lookup (
        .tag_i  (lk_tag),
        .kept_i (words_t'(lk_words)),
        .idx_i  (lk_index),
        .word_o (lk_word)
    );
endmodule

// File: rtl/smc_line_codec_chk.sv
module smc_line_codec_chk
    import smc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmp_in_valid,
    input logic              cmp_in_ready,
    input logic [LINE_W-1:0] cmp_in_line,
    input logic              cmp_out_valid,
    input logic              cmp_out_ready,
    input logic [WORDS-1:0]  cmp_out_tag,
    input logic [LINE_W-1:0] cmp_out_words,
    input logic [CNT_W-1:0]  cmp_out_count,
    input logic              dec_in_valid,
    input logic              dec_in_ready,
    input logic              dec_out_valid,
    input logic              dec_out_ready,
    input logic [LINE_W-1:0] dec_out_line,
    input logic [LINE_W-1:0] lk_words,
    input logic [IDX_W-1:0]  lk_index,
    input logic [WORD_W-1:0] lk_word
);
    p_tag_bit1_r1: assert property (@(posedge clk) disable iff (rst)
        (cmp_in_valid && cmp_in_ready) |=>
            (cmp_out_tag[1] == ($past(cmp_in_line[2*WORD_W-1:WORD_W]) != $past(cmp_in_line[WORD_W-1:0]))));

    p_tag_lsb_r2: assert property (@(posedge clk) disable iff (rst)
        cmp_out_valid |-> cmp_out_tag[0]);

    p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
        cmp_out_valid |-> (cmp_out_count >= CNT_W'(1) && cmp_out_count <= CNT_W'(WORDS)));

    p_lookup_slot0_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_index == '0) |-> (lk_word == lk_words[WORD_W-1:0]));

    p_cmp_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_in_valid && cmp_in_ready) |=> cmp_out_valid);

    p_dec_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_in_valid && dec_in_ready) |=> dec_out_valid);

    p_cmp_block_r8: assert property (@(posedge clk) disable iff (rst)
        cmp_out_valid |-> !cmp_in_ready);

    p_dec_block_r8: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid |-> !dec_in_ready);

    p_cmp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmp_out_valid && !cmp_out_ready) |=>
            (cmp_out_valid && $stable(cmp_out_tag) && $stable(cmp_out_words) && $stable(cmp_out_count)));

    p_dec_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (dec_out_valid && !dec_out_ready) |=> (dec_out_valid && $stable(dec_out_line)));
endmodule

bind smc_line_codec smc_line_codec_chk u_chk (.*);

// File: tb/smc_line_codec_test.sv
`timescale 1ns/1ps
module smc_line_codec_test;
    import smc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              cmp_in_valid = 0, cmp_in_ready, cmp_out_valid, cmp_out_ready = 1;
    logic [LINE_W-1:0] cmp_in_line = '0, cmp_out_words;
    logic [WORDS-1:0]  cmp_out_tag;
    logic [CNT_W-1:0]  cmp_out_count;
    logic              dec_in_valid = 0, dec_in_ready, dec_out_valid, dec_out_ready = 1;
    logic [WORDS-1:0]  dec_in_tag = '0;
    logic [LINE_W-1:0] dec_in_words = '0, dec_out_line;
    logic [WORDS-1:0]  lk_tag = '0;
    logic [LINE_W-1:0] lk_words = '0;
    logic [IDX_W-1:0]  lk_index = '0;
    logic [WORD_W-1:0] lk_word;

    smc_line_codec uut (.*);

    typedef struct {
        tag_t   tag;
        cnt_t   cnt;
        words_t kept;
    } exp_t;

    exp_t   cq[$];
    words_t dq[$];
    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(words_t w);
        exp_t r;
        int k = 0;
        r.kept = '0;
        r.tag  = '0;
        for (int i = 0; i < int'(WORDS); i++) begin
            if (i == 0 || w[i] != w[i-1]) begin
                r.tag[i]  = 1'b1;
                r.kept[k] = w[i];
                k++;
            end
        end
        r.cnt = cnt_t'(k);
        return r;
    endfunction

    // Monitors: pop expected items as results are taken.
    always @(negedge clk) begin
        if (!rst && cmp_out_valid && cmp_out_ready) begin
            if (cq.size() == 0) begin
                check(1'b0, "R7 unexpected compress output", 1, 0);
            end else begin
                exp_t e;
                e = cq.pop_front();
                check(cmp_out_tag == e.tag, "R1/R2 keep mask", cmp_out_tag, e.tag);
                check(cmp_out_count == e.cnt, "R4 kept count", cmp_out_count, e.cnt);
                check(cmp_out_words == e.kept, "R3 packed words", cmp_out_words, e.kept);
            end
        end
        if (!rst && dec_out_valid && dec_out_ready) begin
            if (dq.size() == 0) begin
                check(1'b0, "R7 unexpected decompress output", 1, 0);
            end else begin
                words_t l;
                l = dq.pop_front();
                check(dec_out_line == l, "R5/R9 rebuilt line", dec_out_line, l);
            end
        end
    end

    task automatic send_cmp(input words_t w);
        cq.push_back(model(w));
        @(negedge clk);
        cmp_in_line  = w;
        cmp_in_valid = 1'b1;
        while (!cmp_in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmp_in_valid = 1'b0;
        check(cmp_out_valid, "R7 compress valid one cycle after accept", cmp_out_valid, 1);
    endtask

    task automatic send_dec(input tag_t t, input words_t k, input words_t expect_line);
        dq.push_back(expect_line);
        @(negedge clk);
        dec_in_tag   = t;
        dec_in_words = k;
        dec_in_valid = 1'b1;
        while (!dec_in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        dec_in_valid = 1'b0;
        check(dec_out_valid, "R7 decompress valid one cycle after accept", dec_out_valid, 1);
    endtask

    task automatic lookup(input words_t w, input int idx);
        exp_t e;
        e = model(w);
        @(negedge clk);
        lk_tag   = e.tag;
        lk_words = e.kept;
        lk_index = idx_t'(idx);
        #1;
        check(lk_word == w[idx], "R6 word lookup", lk_word, w[idx]);
    endtask

    function automatic words_t pattern(int kind);
        words_t w;
        for (int i = 0; i < int'(WORDS); i++) begin
            case (kind)
                0: w[i] = 32'h5A5A_0001;
                1: w[i] = 32'h0000_1000 + i;
                2: w[i] = (i % 2) ? 32'hAAAA_AAAA : 32'h5555_5555;
                3: w[i] = (i < 3) ? 32'hC000_0000 + i : (i < 13) ? 32'hC000_0002 : 32'hDEAD_BEEF;
                4: w[i] = '0;
                default: w[i] = (i == int'(WORDS) - 1) ? 32'h0000_0007 : 32'h0000_0003;
            endcase
        end
        return w;
    endfunction

    task automatic run_line(input words_t w);
        exp_t e;
        e = model(w);
        send_cmp(w);
        send_dec(e.tag, e.kept, w);
        lookup(w, 0);
        lookup(w, 7);
        lookup(w, 12);
        lookup(w, int'(WORDS) - 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!cmp_out_valid && !dec_out_valid, "R8 outputs idle after reset", {cmp_out_valid, dec_out_valid}, 0);
        check(cmp_in_ready && dec_in_ready, "R8 inputs ready after reset", {cmp_in_ready, dec_in_ready}, 3);

        for (int p = 0; p < 6; p++) begin
            run_line(pattern(p));
        end

        // R5: mask bit 0 cleared on the decompress input must not matter.
        begin
            words_t w;
            exp_t e;
            w = pattern(3);
            e = model(w);
            send_dec(e.tag & ~tag_t'(1), e.kept, w);
        end

        // R8: back-pressure on the compress output.
        begin
            tag_t t0;
            @(negedge clk);
            cmp_out_ready = 1'b0;
            send_cmp(pattern(3));
            t0 = cmp_out_tag;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                check(!cmp_in_ready, "R8 ready low while output held", cmp_in_ready, 0);
                check(cmp_out_valid && cmp_out_tag == t0, "R8 output held stable", cmp_out_tag, t0);
            end
            cmp_out_ready = 1'b1;
        end

        // Mixed runs from a small alphabet.
        for (int r = 0; r < 20; r++) begin
            words_t w;
            for (int i = 0; i < int'(WORDS); i++) begin
                w[i] = 32'h0100_0000 + ($urandom % 3);
            end
            run_line(w);
        end

        repeat (4) @(negedge clk);
        check(cq.size() == 0 && dq.size() == 0, "R7 every request answered", cq.size() + dq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule